// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block watches for a stalled processor in two stages. Once armed, a wide primary down-counter counts from a programmable reload value to zero, one step per system clock. When it runs out, the block sets a sticky overflow flag and raises an interrupt unless software has masked it. It then starts a narrow secondary down-counter. The secondary counter steps once every sixteen clocks through a prescaler. If the secondary counter also runs out, the block emits a one-cycle time-out pulse that asks the system for a reset.

Software services the timer only by writing one fixed 32-bit key to the restart register. The same key write also arms a disarmed timer, and so does a high level on the external enable pin. After it is armed, nothing short of a system reset disarms it. The register port is a plain single-cycle write strobe with a combinational read. There is no stream traffic, so no valid/ready handshake and no back-pressure apply.

Register map, selected by the 2-bit address: 0 = reload value (read/write); 1 = restart (write-only, reads 0); 2 = control/status; 3 = live primary count (read-only).

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the timer is disarmed, irq_o and tout_o are low, and the reload register reads 0xFFFFFFFF. The control/status register reads 0x0000FF00: bit 0 mask = 0, bit 1 overflow = 0, bit 2 armed = 0, bits [15:8] secondary count = 255.
- R2: The timer arms on a clock edge where wd_en_i is high, or where address 1 is written with 0x ECD9F7BD (key 0xECD9F7BD). A write of any other value to address 1 neither arms nor restarts it.
- R3: Once armed (control bit 2 = 1), the timer stays armed until reset, even if wd_en_i falls.
- R4: While disarmed, address 3 shows the reload value. From the edge that arms or restarts the timer with reload L, address 3 shows L and then drops by one per clock. The overflow flag appears L+1 clocks after that edge.
- R5: irq_o is high exactly while the overflow flag is set and the mask bit is clear.
- R6: After overflow, the secondary count (control bits [15:8]) drops by one every 16 clocks. tout_o rises 16*255 clocks after the overflow flag appears.
- R7: tout_o is high for one clock only. After it, both counts and the overflow flag hold, and key writes are ignored until reset.
- R8: A key write while armed (before time-out) reloads the primary count, returns the secondary count to 255, restarts the prescaler, and clears the overflow flag and irq_o.
- R9: The overflow flag is read-only. Writing control bit 1 does not change it, while writing bit 0 sets the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wd_en_i | input | 1 | External arm request, sampled each edge |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Expiry interrupt request (level) |
| tout_o | output | 1 | One-clock system reset request |

## Verification
The assertions assume one register access per clock, a known address whenever the write strobe is high, and wd_en_i changing only between edges. The random trials draw small reload values, arm by pin or by key, and insert restarts only before the primary count expires. Non-key writes carry a value forced to differ from the key. This keeps every expected interrupt and overflow time a simple function of the last restart edge. Only the few directed runs wait through the full grace period to reach a time-out.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    RA_LOAD  = 2'd0,
    RA_KICK  = 2'd1,
    RA_CTRL  = 2'd2,
    RA_COUNT = 2'd3
  } wd_reg_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_GRACE = 2'd2,
    PH_DONE  = 2'd3
  } wd_phase_e;

  localparam int CTRL_MASK    = 0;
  localparam int CTRL_OVF     = 1;
  localparam int CTRL_ARMED   = 2;
  localparam int CTRL_SEC_LSB = 8;
endpackage

// File: rtl/wdog_dcount.sv
module wdog_dcount #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      cnt_q <= RST_VAL;
    else if (load_i)  cnt_q <= load_val_i;
    else if (dec_i)   cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && dec_i && !load_i) |=> zero_o);
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clr_i)  div_q <= '0;
    else if (run_i)        div_q <= (div_q == LAST) ? '0 : div_q + PW'(1);
  end

  assign tick_o = run_i && (div_q == LAST);

  a_r6_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && DIV > 1) |=> !tick_o);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int            CNT_W    = 32,
  parameter int            SEC_W    = 8,
  parameter int            PRE_DIV  = 16,
  parameter logic [31:0]   KEY      = 32'hECD9_F7BD,
  parameter logic [CNT_W-1:0] LOAD_RST = '1,
  parameter logic [SEC_W-1:0] SEC_INIT = '1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wd_en_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic        tout_o
);
  localparam int SEC_HI = CTRL_SEC_LSB + SEC_W;

  wd_phase_e        phase_q, phase_d;
  wd_reg_e          addr;
  logic [CNT_W-1:0] load_q;
  logic             mask_q, ovf_q, tout_q;
  logic             key_wr, kick_ok;
  logic [CNT_W-1:0] p_cnt;
  logic             p_zero, p_load, p_dec;
  logic [SEC_W-1:0] s_cnt;
  logic             s_zero, s_load, s_dec;
  logic             tick, s_last, fire;
  logic [31:0]      ctrl_rd;

  assign addr    = wd_reg_e'(reg_addr_i);
  assign key_wr  = reg_we_i && (addr == RA_KICK) && (reg_wdata_i == KEY);
  assign kick_ok = key_wr && (phase_q != PH_DONE);

  // primary stage: tracks the reload value while idle, counts while running
  assign p_load = (phase_q == PH_IDLE) || kick_ok;
  assign p_dec  = (phase_q == PH_RUN) && !p_zero;

  wdog_dcount #(.W(CNT_W), .RST_VAL(LOAD_RST)) u_primary (
    .clk_i, .rst_ni,
    .load_i(p_load), .load_val_i(load_q), .dec_i(p_dec),
    .cnt_o(p_cnt), .zero_o(p_zero)
  );

  // grace stage: prescaled secondary countdown
  wdog_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk_i, .rst_ni,
    .clr_i(phase_q != PH_GRACE || kick_ok),
    .run_i(phase_q == PH_GRACE),
    .tick_o(tick)
  );

  assign s_load = (phase_q == PH_IDLE) || (phase_q == PH_RUN) || kick_ok;
  assign s_dec  = (phase_q == PH_GRACE) && tick;

  wdog_dcount #(.W(SEC_W), .RST_VAL(SEC_INIT)) u_secondary (
    .clk_i, .rst_ni,
    .load_i(s_load), .load_val_i(SEC_INIT), .dec_i(s_dec),
    .cnt_o(s_cnt), .zero_o(s_zero)
  );

  assign s_last = (s_cnt == SEC_W'(1));
  assign fire   = (phase_q == PH_GRACE) && !kick_ok && tick && s_last;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (wd_en_i || key_wr) phase_d = PH_RUN;
      PH_RUN:   if (!kick_ok && p_zero) phase_d = PH_GRACE;
      PH_GRACE: if (kick_ok) phase_d = PH_RUN;
                else if (fire) phase_d = PH_DONE;
      PH_DONE:  phase_d = PH_DONE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      load_q  <= LOAD_RST;
      mask_q  <= 1'b0;
      ovf_q   <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tout_q  <= fire;
      if (reg_we_i && addr == RA_LOAD) load_q <= reg_wdata_i[CNT_W-1:0];
      if (reg_we_i && addr == RA_CTRL) mask_q <= reg_wdata_i[CTRL_MASK];
      if (kick_ok)
        ovf_q <= 1'b0;
      else if (phase_q == PH_RUN && p_zero)
        ovf_q <= 1'b1;
    end
  end

  always_comb begin
    ctrl_rd                       = '0;
    ctrl_rd[CTRL_MASK]            = mask_q;
    ctrl_rd[CTRL_OVF]             = ovf_q;
    ctrl_rd[CTRL_ARMED]           = (phase_q != PH_IDLE);
    ctrl_rd[SEC_HI-1:CTRL_SEC_LSB] = s_cnt;
  end

  always_comb begin
    unique case (addr)
      RA_LOAD:  reg_rdata_o = 32'(load_q);
      RA_CTRL:  reg_rdata_o = ctrl_rd;
      RA_COUNT: reg_rdata_o = 32'(p_cnt);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o  = ovf_q && !mask_q;
  assign tout_o = tout_q;

  // ---------------- assertions ----------------
  a_r1_quiet_after_reset: assert property (@(posedge clk_i)
    !rst_ni |=> (phase_q == PH_IDLE && !ovf_q && !tout_q));

  a_r2_stay_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !wd_en_i && !key_wr) |=> (phase_q == PH_IDLE));

  a_r3_sticky_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |=> (phase_q != PH_IDLE));

  a_r4_primary_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN && !kick_ok && !p_zero) |=> (p_cnt == $past(p_cnt) - CNT_W'(1)));

  a_r6_secondary_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_GRACE && !tick && !kick_ok) |=> $stable(s_cnt));

  a_r7_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_o |=> !tout_o);

  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DONE) |=> ($stable(p_cnt) && $stable(s_cnt) && ovf_q));

  a_r7_fires_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tout_o) |-> (s_zero && ovf_q));

  a_r8_kick_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_ok |=> (!ovf_q && !irq_o && p_cnt == $past(load_q) && s_cnt == SEC_INIT));
endmodule

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;
  localparam logic [31:0] KEY   = 32'hECD9_F7BD;
  localparam logic [1:0]  A_LD  = 2'd0, A_KICK = 2'd1, A_CTRL = 2'd2, A_CNT = 2'd3;
  localparam int          SEC0  = 255;
  localparam int          DIV   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, tout;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wdog_two_stage u0 (
    .clk_i(clk), .rst_ni(rst_n), .wd_en_i(en),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .tout_o(tout)
  );

  function automatic int ovf_delay(input int l);
    return l + 1;
  endfunction

  function automatic int tout_delay(input int s);
    return DIV * s;
  endfunction

  function automatic logic [31:0] ctrl_word(input int sec, input bit armed,
                                            input bit ovf, input bit mask);
    return (32'(sec) << 8) | (32'(armed) << 2) | (32'(ovf) << 1) | 32'(mask);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  // drives at a negedge, lets one posedge take it, returns at the next negedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic arm_by_pin();
    en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    en = 1'b0;
  endtask

  // counts negedges until the overflow bit shows; already at n = start
  task automatic wait_ovf(input int start, output int n);
    logic [31:0] d;
    n = start;
    rd(A_CTRL, d);
    while (d[1] == 1'b0 && n < 5000) begin
      @(negedge clk); n++;
      rd(A_CTRL, d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, l;
    void'($urandom(32'd2718));

    // ---- R1: reset state ----
    do_reset();
    rd(A_LD, d);   check("R1 reload reset", d, 32'hFFFF_FFFF);
    rd(A_CTRL, d); check("R1 ctrl reset", d, ctrl_word(SEC0, 0, 0, 0));
    check("R1 irq low", 32'(irq), 0);
    check("R1 tout low", 32'(tout), 0);

    // ---- R2: wrong key ignored ----
    l = 20;
    wr(A_LD, 32'(l));
    wr(A_KICK, KEY ^ 32'h1);
    repeat (30) @(negedge clk);
    rd(A_CTRL, d); check("R2 wrong key does not arm", d, ctrl_word(SEC0, 0, 0, 0));
    rd(A_CNT, d);  check("R4 idle count follows reload", d, 32'(l));

    // ---- pin arm, full escalation to time-out ----
    arm_by_pin();
    rd(A_CNT, d); check("R4 count at arm edge", d, 32'(l));
    @(negedge clk); @(negedge clk);
    rd(A_CNT, d); check("R4 count after 2 clocks", d, 32'(l - 2));
    rd(A_CTRL, d); check("R3 armed after pin falls", 32'(d[2]), 1);
    wait_ovf(2, n);
    check("R4 overflow delay", 32'(n), 32'(ovf_delay(l)));
    check("R5 irq with mask clear", 32'(irq), 1);
    n = 0;
    while (!tout && n < 6000) begin
      @(negedge clk); n++;
      if (n == 3 * DIV) begin
        rd(A_CTRL, d); check("R6 secondary after 3 ticks", 32'(d[15:8]), 32'(SEC0 - 3));
      end
    end
    check("R6 time-out delay", 32'(n), 32'(tout_delay(SEC0)));
    @(negedge clk);
    check("R7 time-out single cycle", 32'(tout), 0);
    wr(A_KICK, KEY);
    repeat (4) @(negedge clk);
    rd(A_CNT, d);  check("R7 primary frozen", d, 0);
    rd(A_CTRL, d); check("R7 ovf held, key ignored", d, ctrl_word(0, 1, 1, 0));
    check("R7 no second pulse", 32'(tout), 0);

    // ---- R9 / R5 masked / R8 restart in grace ----
    do_reset();
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, d); check("R9 ovf not writable", d, ctrl_word(SEC0, 0, 0, 1));
    l = 12;
    wr(A_LD, 32'(l));
    wr(A_KICK, KEY);
    rd(A_CTRL, d); check("R2 key arms", 32'(d[2]), 1);
    wait_ovf(0, n);
    check("R4 overflow delay after key arm", 32'(n), 32'(ovf_delay(l)));
    check("R5 irq masked", 32'(irq), 0);
    repeat (40) @(negedge clk);
    wr(A_KICK, KEY);
    rd(A_CTRL, d); check("R8 restart clears ovf and secondary", d, ctrl_word(SEC0, 1, 0, 1));
    rd(A_CNT, d);  check("R8 restart reloads primary", d, 32'(l));
    check("R8 irq low after restart", 32'(irq), 0);
    wr(A_CTRL, 32'h0);
    wait_ovf(1, n);
    check("R4 overflow delay after restart", 32'(n), 32'(ovf_delay(l)));
    check("R5 irq unmasked", 32'(irq), 1);

    // ---- constrained random trials ----
    for (int t = 0; t < 20; t++) begin
      int kicks, w, g;
      logic [31:0] bad;
      do_reset();
      l = $urandom_range(40, 2);
      wr(A_LD, 32'(l));
      if ($urandom_range(1, 0) == 1) arm_by_pin();
      else wr(A_KICK, KEY);
      kicks = $urandom_range(3, 0);
      for (int k = 0; k < kicks; k++) begin
        w = $urandom_range(l - 1, 0);
        repeat (w) @(negedge clk);
        wr(A_KICK, KEY);
      end
      bad = $urandom();
      if (bad == KEY) bad = bad ^ 32'h1;
      wr(A_KICK, bad);
      wait_ovf(1, n);
      check("R2 R4 random overflow delay", 32'(n), 32'(ovf_delay(l)));
      check("R5 random irq", 32'(irq), 1);
      g = $urandom_range(300, 1);
      repeat (g) @(negedge clk);
      wr(A_KICK, KEY);
      rd(A_CTRL, d); check("R8 random grace restart", d, ctrl_word(SEC0, 1, 0, 0));
      rd(A_CNT, d);  check("R8 random reload", d, 32'(l));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule